// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the serial side of a voice codec's PCM bus. Transmit and receive each have their own frame-sync input, and both share one bit clock, which is the block's clock `clk`. Each frame-sync rising edge marks the start of a frame. The block counts bit positions from that point. When the position reaches the assigned time-slot, it shifts one 8-bit sample out, most significant bit first, on one of two transmit lanes. It also drives that lane's active-low enable for an external backplane driver. In the same way it collects one 8-bit sample, most significant bit first, from one of two receive lines.

Two framing relationships are supported. In the immediate mode, the slot begins with the frame-sync edge itself. In the delayed mode, the slot begins one bit clock after the frame sync is seen. Programmable slot numbers apply only in the delayed mode; in the immediate mode slot 0 is always used. Transmit and receive count independently, so their frames may be offset by any number of bit clocks. A power-down input turns both transmit lanes off and stops receive delivery.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst_n` is low, `dx_oe` is 00, `tx_drv_en_n` is 11 and `rx_valid` is 0.
- R2: With `delayed_mode`=0, the transmit slot occupies the eight cycles that begin with the cycle after the rising clock edge that first samples `tx_fs` high.
- R3: With `delayed_mode`=1, every slot starts one cycle later than in R2.
- R4: With `delayed_mode`=1 and a slot enable set, slot k (6-bit `*_tsa_slot`) occupies bit positions 8k to 8k+7 after the frame start. With the enable clear, slot 0 is used.
- R5: With `delayed_mode`=0, the slot enables and slot numbers are ignored and slot 0 is used.
- R6: `tx_byte` is captured at the rising edge that begins the slot, and later changes to it do not alter the bits shifted out. Bit 7 goes out first, and one bit is sent per cycle.
- R7: Only the lane indexed by `tx_sel` (0 gives lane 0, 1 gives lane 1) has `dx_oe` high, and only during its slot. `dx_data` is 0 whenever `dx_oe` is low.
- R8: The selected `tx_drv_en_n` bit is low from the start of the slot until the falling clock edge in the middle of the eighth bit, and is high otherwise.
- R9: Receive bits are sampled from `rx_din[rx_sel]` on the eight falling edges of the receive slot, most significant bit first. `rx_byte` is presented with a single-cycle `rx_valid` in the cycle after the slot.
- R10: Transmit and receive slot timing follow their own frame syncs, which may be skewed by any number of cycles.
- R11: Only a frame-sync rising edge starts a frame. The pulse may last one cycle or many, and holding it high does not restart the frame.
- R12: While `power_down` is high, `dx_oe` is 00, `tx_drv_en_n` is 11, and no `rx_valid` is produced for a slot that ends during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_down | input | 1 | Forces the transmit lanes off and blocks receive delivery |
| delayed_mode | input | 1 | 0 selects immediate framing, 1 selects delayed framing |
| tx_fs | input | 1 | Transmit frame sync |
| tx_tsa_en | input | 1 | Transmit slot-number enable |
| tx_tsa_slot | input | 6 | Transmit slot number |
| tx_sel | input | 1 | Transmit lane select |
| tx_byte | input | 8 | Sample to transmit |
| rx_fs | input | 1 | Receive frame sync |
| rx_tsa_en | input | 1 | Receive slot-number enable |
| rx_tsa_slot | input | 6 | Receive slot number |
| rx_sel | input | 1 | Receive line select |
| rx_din | input | 2 | Receive serial lines |
| dx_data | output | 2 | Transmit serial data per lane |
| dx_oe | output | 2 | Pad output enable per lane (low = high impedance) |
| tx_drv_en_n | output | 2 | Active-low backplane driver enable per lane |
| rx_byte | output | 8 | Received sample |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |

## Verification
The bench uses the default parameters: 6-bit slot numbers, 8-bit samples and two lanes per direction. This makes the highest slot (63, bit positions 504 to 511) reachable within one frame, together with lane 1 of both directions. A behavioural model tracks each frame in integers and compares every lane, enable and receive strobe on every rising edge. The half-bit release of the driver enable is checked on every falling edge.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  // First bit position of a slot counted from frame start.
  function automatic int slot_base(input int slot, input int data_w);
    return slot * data_w;
  endfunction

  // Position lies inside the slot window [base, base+len).
  function automatic logic in_window(input int pos, input int base, input int len);
    return (pos >= base) && (pos < base + len);
  endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_slot_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              delayed,
  input  logic              tsa_en,
  input  logic [SLOT_W-1:0] tsa_slot,
  output logic              active,
  output logic              load,
  output logic              last_bit
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int POS_W = SLOT_W + BIT_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             fs_q, start_d, fs_rise, start;
  logic [POS_W-1:0] pos, pos_next, base;
  logic [SLOT_W-1:0] eff_slot;
  logic [BIT_W-1:0] bit_idx;

  assign fs_rise  = fs & ~fs_q;
  assign start    = delayed ? start_d : fs_rise;
  assign pos_next = start ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
  assign eff_slot = (delayed && tsa_en) ? tsa_slot : '0;
  assign base     = POS_W'(slot_base(int'(eff_slot), DATA_W));
  assign active   = in_window(int'(pos), int'(base), DATA_W);
  assign load     = (pos_next == base);
  assign bit_idx  = BIT_W'(pos - base);
  assign last_bit = active && (bit_idx == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      start_d <= 1'b0;
      pos     <= POS_MAX;
    end else begin
      fs_q    <= fs;
      start_d <= fs_rise;
      pos     <= pos_next;
    end
  end

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos == '0)); // R2
  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && pos != POS_MAX) |=> (pos == $past(pos) + 1'b1)); // R11
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int DATA_W = 8,
  parameter int LANES  = 2,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic              last_bit,
  input  logic              power_down,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [LANES-1:0]  dx_data,
  output logic [LANES-1:0]  dx_oe,
  output logic [LANES-1:0]  drv_en_n
);
  logic [DATA_W-1:0] sh;
  logic              half_q;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (load)   sh <= tx_byte;
    else if (active) sh <= {sh[DATA_W-2:0], 1'b0};
  end

  // Set on the falling edge inside the last bit: releases the driver enable.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= last_bit;
  end

  assign drive = active & ~power_down;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dx_oe[g]    = drive && (sel == SEL_W'(g));
    assign dx_data[g]  = dx_oe[g] ? sh[DATA_W-1] : 1'b0;
    assign drv_en_n[g] = ~(dx_oe[g] && !(half_q && last_bit));
  end

  AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dx_oe)); // R7
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sh == $past(tx_byte))); // R6
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int DATA_W = 8,
  parameter int LANES  = 2,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              last_bit,
  input  logic              power_down,
  input  logic [SEL_W-1:0]  sel,
  input  logic [LANES-1:0]  din,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic [DATA_W-1:0] sh;
  logic              done;

  assign done = last_bit && !power_down;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                     sh <= '0;
    else if (active && !power_down) sh <= {sh[DATA_W-2:0], din[sel]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= done;
      if (done) rx_byte <= sh;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_PD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(power_down) |-> !rx_valid); // R12
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 8,
  parameter int LANES  = 2,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_down,
  input  logic              delayed_mode,
  input  logic              tx_fs,
  input  logic              tx_tsa_en,
  input  logic [SLOT_W-1:0] tx_tsa_slot,
  input  logic [SEL_W-1:0]  tx_sel,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_fs,
  input  logic              rx_tsa_en,
  input  logic [SLOT_W-1:0] rx_tsa_slot,
  input  logic [SEL_W-1:0]  rx_sel,
  input  logic [LANES-1:0]  rx_din,
  output logic [LANES-1:0]  dx_data,
  output logic [LANES-1:0]  dx_oe,
  output logic [LANES-1:0]  tx_drv_en_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic tx_active, tx_load, tx_last;
  logic rx_active, rx_load, rx_last;

  pcm_frame_timer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_tx_timer (
    .clk(clk), .rst_n(rst_n), .fs(tx_fs), .delayed(delayed_mode),
    .tsa_en(tx_tsa_en), .tsa_slot(tx_tsa_slot),
    .active(tx_active), .load(tx_load), .last_bit(tx_last));

  pcm_frame_timer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx_timer (
    .clk(clk), .rst_n(rst_n), .fs(rx_fs), .delayed(delayed_mode),
    .tsa_en(rx_tsa_en), .tsa_slot(rx_tsa_slot),
    .active(rx_active), .load(rx_load), .last_bit(rx_last));

  pcm_tx_lane #(.DATA_W(DATA_W), .LANES(LANES)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(tx_active), .load(tx_load),
    .last_bit(tx_last), .power_down(power_down), .sel(tx_sel),
    .tx_byte(tx_byte), .dx_data(dx_data), .dx_oe(dx_oe),
    .drv_en_n(tx_drv_en_n));

  pcm_rx_lane #(.DATA_W(DATA_W), .LANES(LANES)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(rx_active), .last_bit(rx_last),
    .power_down(power_down), .sel(rx_sel), .din(rx_din),
    .rx_byte(rx_byte), .rx_valid(rx_valid));

  // The receive timer's load flag has no consumer; it is checked against its window here.
  AST_RX_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (rx_active || $past(rx_active) || !rx_valid)); // R10
endmodule

// File: tb/pcm_slot_port_tb_top.sv
`timescale 1ns/1ps
module pcm_slot_port_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, pd = 1'b0, dm = 1'b0;
  logic       tfs = 1'b0, ten = 1'b0, tsel = 1'b0, rfs = 1'b0, ren = 1'b0, rsel = 1'b0;
  logic [5:0] tslot = '0, rslot = '0;
  logic [7:0] tbyte = '0;
  logic [1:0] din = '0;
  logic [1:0] dxd, dxo, tsxn;
  logic [7:0] rbyte;
  logic       rvalid;

  pcm_slot_port dut_i (
    .clk(clk), .rst_n(rst_n), .power_down(pd), .delayed_mode(dm),
    .tx_fs(tfs), .tx_tsa_en(ten), .tx_tsa_slot(tslot), .tx_sel(tsel), .tx_byte(tbyte),
    .rx_fs(rfs), .rx_tsa_en(ren), .rx_tsa_slot(rslot), .rx_sel(rsel), .rx_din(din),
    .dx_data(dxd), .dx_oe(dxo), .tx_drv_en_n(tsxn), .rx_byte(rbyte), .rx_valid(rvalid));

  int    checks = 0, errors = 0;
  string ttag = "R2", rtag = "R9";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Inputs change 2 ns after each rising edge.
  initial forever begin
    @(posedge clk); #2;
    tbyte = 8'($urandom);
    din   = 2'($urandom);
  end

  // Behavioural reference: integer bit positions per direction.
  int  tpos, rpos, tbase, rbase, tq, racc, rsnap;
  bit  tprev, tpend, rprev, rpend, rfin, tact;
  localparam int PMAX = 1023;

  initial forever begin
    bit st, ev;
    @(posedge clk); #1;
    if (!rst_n) begin
      tpos = PMAX; rpos = PMAX; tprev = 0; tpend = 0; rprev = 0; rpend = 0;
      rfin = 0; tact = 0; tq = 0; racc = 0;
      chk(dxo == 2'b00, "R1", "dx_oe in reset", dxo, 0);
      chk(tsxn == 2'b11, "R1", "drv_en_n in reset", tsxn, 3);
      chk(rvalid == 1'b0, "R1", "rx_valid in reset", rvalid, 0);
    end else begin
      chk(rvalid == rfin, rtag, "rx_valid", rvalid, rfin);
      if (rfin && rvalid) chk(rbyte == 8'(rsnap), rtag, "rx_byte", rbyte, rsnap);
      rfin = 0;
      // transmit frame
      st = dm ? tpend : (tfs && !tprev);
      tpend = tfs && !tprev; tprev = tfs;
      tpos = st ? 0 : (tpos < PMAX ? tpos + 1 : tpos);
      tbase = ((dm && ten) ? int'(tslot) : 0) * 8;
      if (tpos == tbase) tq = int'(tbyte);
      tact = (tpos >= tbase) && (tpos < tbase + 8);
      // receive frame
      st = dm ? rpend : (rfs && !rprev);
      rpend = rfs && !rprev; rprev = rfs;
      rpos = st ? 0 : (rpos < PMAX ? rpos + 1 : rpos);
      rbase = ((dm && ren) ? int'(rslot) : 0) * 8;
      for (int i = 0; i < 2; i++) begin
        ev = tact && !pd && (int'(tsel) == i);
        chk(dxo[i] == ev, ev ? ttag : "R7", "dx_oe", dxo[i], ev);
        if (ev) chk(dxd[i] == 1'((tq >> (7 - (tpos - tbase))) & 1), ttag, "dx_data",
                    dxd[i], (tq >> (7 - (tpos - tbase))) & 1);
        else    chk(dxd[i] == 1'b0, "R7", "idle dx_data", dxd[i], 0);
        chk(tsxn[i] == !ev, "R8", "drv_en_n first half", tsxn[i], !ev);
      end
    end
    @(negedge clk); #1;
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ev = tact && !pd && (int'(tsel) == i) && (tpos - tbase < 7);
        chk(tsxn[i] == !ev, "R8", "drv_en_n second half", tsxn[i], !ev);
      end
      if ((rpos >= rbase) && (rpos < rbase + 8) && !pd) begin
        racc = ((racc << 1) | int'(din[rsel])) & 255;
        if (rpos - rbase == 7) begin rfin = 1; rsnap = racc; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic phase(input string tt, input string rt, input bit m,
                       input bit te, input int ts, input bit tl,
                       input bit re, input int rs, input bit rl,
                       input int tat, input int tlen, input int rat, input int rlen,
                       input int pat, input int plen, input int n);
    rst_n = 1'b0; tfs = 0; rfs = 0; pd = 0;
    cyc(3);
    ttag = tt; rtag = rt; dm = m; ten = te; tslot = 6'(ts); tsel = tl;
    ren = re; rslot = 6'(rs); rsel = rl;
    rst_n = 1'b1;
    for (int c = 0; c < n; c++) begin
      tfs = (c >= tat) && (c < tat + tlen);
      rfs = (c >= rat) && (c < rat + rlen);
      pd  = (c >= pat) && (c < pat + plen);
      cyc(1);
    end
  endtask

  initial begin
    cyc(4);
    // immediate mode, long sync held high, lane 0
    phase("R2", "R9", 0, 0, 0, 0, 0, 0, 0, 3, 40, 3, 40, 999, 0, 60);
    // fresh bytes every cycle; capture at slot start
    phase("R6", "R9", 0, 0, 0, 0, 0, 0, 0, 5, 2, 5, 2, 999, 0, 40);
    // delayed mode, no slot numbers
    phase("R3", "R9", 1, 0, 9, 0, 0, 9, 0, 2, 1, 2, 1, 999, 0, 40);
    // delayed mode with slot numbers and skewed receive frame
    phase("R4", "R10", 1, 1, 3, 0, 1, 5, 0, 2, 4, 7, 1, 999, 0, 80);
    // immediate mode ignores slot numbers
    phase("R5", "R5", 0, 1, 7, 0, 1, 4, 1, 2, 3, 4, 3, 999, 0, 80);
    // highest slot, lane 1 both ways
    phase("R7", "R9", 1, 1, 63, 1, 1, 62, 1, 1, 1, 0, 1, 999, 0, 530);
    // single-cycle sync, then another frame
    phase("R11", "R11", 0, 0, 0, 1, 0, 0, 0, 1, 1, 2, 1, 999, 0, 20);
    phase("R11", "R11", 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 999, 0, 20);
    // power-down across the slots
    phase("R12", "R12", 0, 0, 0, 0, 0, 0, 1, 2, 1, 2, 1, 0, 30, 40);
    // power-down lifted in the middle of a slot
    phase("R12", "R12", 1, 1, 2, 1, 1, 2, 0, 1, 1, 1, 1, 0, 21, 50);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule